// File: doc/BRIEF.md
# Interrupt Pin Delivery Engine

This block watches a set of interrupt input pins and decides when each one has to become a message to the interrupt controllers further down. Every pin has a configuration entry supplied from outside: a vector number, a trigger type, a mask bit, a destination and a delivery mode. For each pin the block keeps a request bit that follows the pin. A level-triggered pin also has a remote-IRR flag. The flag is set while a delivered level interrupt is still being serviced and cleared by an end-of-interrupt (EOI) that carries the pin's vector.

Messages leave through a one-entry slot with a valid/ready handshake. When a message is accepted, the receiver also reports whether it reached at least one destination. An EOI re-delivers a level pin that is still asserted. A per-pin counter catches interrupt storms: after a set number of back-to-back EOI re-deliveries, the next re-delivery is held back by a programmable delay. When that delay runs out, every level pin that is ready is re-injected. Register access and destination matching belong to other blocks.

Top module: `irq_pin_dispatch`

## Requirements
- R1: After reset no message is offered (msgValid is 0), and all request bits, remote-IRR flags, storm counters and the delay timer are cleared.
- R2: An edge-triggered pin (cfgLevel bit 0) whose request bit rises from 0 to 1 while unmasked produces exactly one message carrying that pin's index, vector and destination. A pin that stays high produces no further messages.
- R3: A pin driven low clears its request bit. A later EOI for its vector then delivers nothing.
- R4: A masked pin (cfgMask bit 1) never produces a message, but its request bit is still recorded.
- R5: A level-triggered pin (cfgLevel bit 1) sets its remote-IRR flag only when its message is accepted with msgHit at 1. While that flag is set, a new rise of the pin sends nothing.
- R6: An EOI with vector V affects only level pins whose vector equals V. It clears their remote-IRR flag and re-delivers each such pin that is unmasked and still requesting. An EOI with a vector that no pin uses changes nothing.
- R7: EOI re-deliveries of a pin are counted. The EOI that would make the count reach STORM_LIMIT resets the count, and it starts a DELAY_CYCLES delay instead of re-delivering at once.
- R8: The storm count of a pin returns to zero whenever an EOI finds that pin not requesting or masked.
- R9: When the delay expires, every unmasked level pin that is requesting and has its remote-IRR flag clear is delivered.
- R10: A strobe on cfgWrite for a pin clears that pin's remote-IRR flag. If the entry is level-triggered, unmasked and the pin is requesting, the pin is delivered.
- R11: Pins that are ready in the same cycle are sent lowest index first, one message per accepted handshake.
- R12: While msgValid is 1 and msgReady is 0, the message and its pin index stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinLevel | input | NUM_PINS | Current level of each interrupt pin |
| cfgVector | input | NUM_PINS*VEC_W | Vector for each pin, pin i in bits [i*VEC_W +: VEC_W] |
| cfgDest | input | NUM_PINS*DEST_W | Destination for each pin |
| cfgDelMode | input | NUM_PINS*DMODE_W | Delivery mode for each pin |
| cfgLevel | input | NUM_PINS | 1 = level-triggered, 0 = edge-triggered |
| cfgMask | input | NUM_PINS | 1 = pin masked |
| cfgWrite | input | NUM_PINS | One-cycle strobe: the entry of that pin was rewritten |
| eoiValid | input | 1 | End-of-interrupt notification present |
| eoiVector | input | VEC_W | Vector carried by the EOI |
| msgValid | output | 1 | Message offered downstream |
| msgReady | input | 1 | Downstream takes the message |
| msgHit | input | 1 | With msgReady: message reached at least one destination |
| msgPin | output | PIN_W | Index of the pin that sent the message |
| msgVector | output | VEC_W | Vector of the message |
| msgDest | output | DEST_W | Destination of the message |
| msgDelMode | output | DMODE_W | Delivery mode of the message |
| msgLevel | output | 1 | Trigger type of the message |

## Verification
The hardest state to reach from the ports is the storm threshold. A level pin has to be re-delivered over and over, and each time an EOI has to arrive while the pin is still high and its remote-IRR flag is set. The bench lowers the threshold and the delay through parameters. It keeps one pin high and accepts each message with a hit, then answers with EOIs in a loop until the limit is reached. It also leaves a second level pin requesting, with its flag clear, so the timed re-injection has to pick up both pins in index order. The counter reset is tested the same way, by dropping the pin one EOI short of the limit.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  // strobes from the control unit to the pin bank
  typedef struct packed {
    logic loadSlot;   // capture the selected pin into the message slot
    logic takeSlot;   // downstream accepted the slot
    logic takeHit;    // accepted and reached a destination
    logic delayFire;  // storm delay expired this cycle
  } ctlStrb_t;
endpackage

// File: rtl/irq_pin_bank.sv
module irq_pin_bank
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int VEC_W       = 8,
  parameter int DEST_W      = 8,
  parameter int DMODE_W     = 3,
  parameter int STORM_LIMIT = 10000,
  parameter int PIN_W       = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PINS-1:0]         pinLevel,
  input  logic [NUM_PINS*VEC_W-1:0]   cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0]  cfgDest,
  input  logic [NUM_PINS*DMODE_W-1:0] cfgDelMode,
  input  logic [NUM_PINS-1:0]         cfgLevel,
  input  logic [NUM_PINS-1:0]         cfgMask,
  input  logic [NUM_PINS-1:0]         cfgWrite,
  input  logic                        eoiValid,
  input  logic [VEC_W-1:0]            eoiVector,
  input  logic                        msgReady,
  input  ctlStrb_t                    strb,
  input  logic [PIN_W-1:0]            selPin,
  input  logic                        slotValid,
  output logic [NUM_PINS-1:0]         eligible,
  output logic                        stormReq,
  output logic [PIN_W-1:0]            msgPin,
  output logic [VEC_W-1:0]            msgVector,
  output logic [DEST_W-1:0]           msgDest,
  output logic [DMODE_W-1:0]          msgDelMode,
  output logic                        msgLevel
);
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);

  logic [NUM_PINS-1:0] irrVec;
  logic [NUM_PINS-1:0] remoteVec;
  logic [NUM_PINS-1:0] stormHit;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    logic             irr;
    logic             remoteIrr;
    logic             pend;
    logic [CNT_W-1:0] stormCnt;
    logic             eoiMatch;
    logic             live;
    logic             rise;
    logic             loadMine;
    logic             takeMine;
    logic             pendNext;
    logic             remoteNext;
    logic [CNT_W-1:0] cntNext;

    always_comb begin
      eoiMatch = eoiValid && cfgLevel[gi] &&
                 (cfgVector[gi*VEC_W +: VEC_W] == eoiVector);
      live     = irr && !cfgMask[gi];
      rise     = pinLevel[gi] && !irr;
      loadMine = strb.loadSlot && (selPin == PIN_W'(gi));
      takeMine = strb.takeHit && msgLevel && (msgPin == PIN_W'(gi));
      stormHit[gi] = eoiMatch && live && (stormCnt == CNT_W'(STORM_LIMIT - 1));

      pendNext   = pend;
      remoteNext = remoteIrr;
      cntNext    = stormCnt;
      if (loadMine) pendNext = 1'b0;
      if (takeMine) remoteNext = 1'b1;
      if (rise && !cfgMask[gi] && (!cfgLevel[gi] || !remoteIrr)) pendNext = 1'b1;
      if (cfgWrite[gi]) begin
        remoteNext = 1'b0;
        if (cfgLevel[gi] && live) pendNext = 1'b1;
      end
      if (eoiMatch) begin
        remoteNext = 1'b0;
        if (live) begin
          if (stormHit[gi]) cntNext = '0;
          else begin
            cntNext  = stormCnt + CNT_W'(1);
            pendNext = 1'b1;
          end
        end else begin
          cntNext = '0;
        end
      end
      if (strb.delayFire && cfgLevel[gi] && live && !remoteIrr) pendNext = 1'b1;
      if (cfgLevel[gi] && !pinLevel[gi]) pendNext = 1'b0;
      if (cfgMask[gi]) pendNext = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        irr       <= 1'b0;
        remoteIrr <= 1'b0;
        pend      <= 1'b0;
        stormCnt  <= '0;
      end else begin
        irr       <= pinLevel[gi];
        remoteIrr <= remoteNext;
        pend      <= pendNext;
        stormCnt  <= cntNext;
      end
    end

    assign eligible[gi] = pend && !cfgMask[gi] &&
                          !(cfgLevel[gi] && remoteIrr) &&
                          !(slotValid && msgPin == PIN_W'(gi));
    assign irrVec[gi]    = irr;
    assign remoteVec[gi] = remoteIrr;

    AST_EOI_CLEARS_REMOTE: assert property (@(posedge clk) disable iff (!rstN)
      (eoiMatch && !takeMine) |=> !remoteIrr); // R6

    AST_HIT_SETS_REMOTE: assert property (@(posedge clk) disable iff (!rstN)
      (takeMine && !eoiMatch && !cfgWrite[gi]) |=> remoteIrr); // R5
  end

  assign stormReq = |stormHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgPin     <= '0;
      msgVector  <= '0;
      msgDest    <= '0;
      msgDelMode <= '0;
      msgLevel   <= 1'b0;
    end else if (strb.loadSlot) begin
      msgPin     <= selPin;
      msgVector  <= cfgVector[selPin*VEC_W +: VEC_W];
      msgDest    <= cfgDest[selPin*DEST_W +: DEST_W];
      msgDelMode <= cfgDelMode[selPin*DMODE_W +: DMODE_W];
      msgLevel   <= cfgLevel[selPin];
    end
  end

  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && !msgReady) |=> (slotValid && $stable(msgPin) && $stable(msgVector))); // R12

  AST_LOAD_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSlot |-> !cfgMask[selPin]); // R4

  AST_LEVEL_LOAD_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadSlot && cfgLevel[selPin]) |-> (irrVec[selPin] || pinLevel[selPin] || !remoteVec[selPin])); // R5
endmodule

// File: rtl/irq_deliver_ctl.sv
module irq_deliver_ctl
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS     = 8,
  parameter int DELAY_CYCLES = 1000000,
  parameter int PIN_W        = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] eligible,
  input  logic                stormReq,
  input  logic                msgReady,
  input  logic                msgHit,
  output ctlStrb_t            strb,
  output logic [PIN_W-1:0]    selPin,
  output logic                slotValid
);
  localparam int DCNT_W = $clog2(DELAY_CYCLES + 1);

  logic              timerRun;
  logic [DCNT_W-1:0] timerCnt;

  // lowest index wins
  always_comb begin
    selPin = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (eligible[i]) selPin = PIN_W'(i);
    end
  end

  always_comb begin
    strb.loadSlot  = !slotValid && (|eligible);
    strb.takeSlot  = slotValid && msgReady;
    strb.takeHit   = slotValid && msgReady && msgHit;
    strb.delayFire = timerRun && (timerCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= 1'b0;
    end else if (strb.takeSlot) begin
      slotValid <= 1'b0;
    end else if (strb.loadSlot) begin
      slotValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerRun <= 1'b0;
      timerCnt <= '0;
    end else if (timerRun) begin
      if (timerCnt == '0) timerRun <= 1'b0;
      else                timerCnt <= timerCnt - DCNT_W'(1);
    end else if (stormReq) begin
      timerRun <= 1'b1;
      timerCnt <= DCNT_W'(DELAY_CYCLES - 1);
    end
  end

  AST_TIMER_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (stormReq && !timerRun) |=> timerRun); // R7

  AST_FIRE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.delayFire |=> !timerRun); // R9
endmodule

// File: rtl/irq_pin_dispatch.sv
module irq_pin_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS     = 8,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int DMODE_W      = 3,
  parameter int STORM_LIMIT  = 10000,
  parameter int DELAY_CYCLES = 1000000,
  localparam int PIN_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PINS-1:0]         pinLevel,
  input  logic [NUM_PINS*VEC_W-1:0]   cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0]  cfgDest,
  input  logic [NUM_PINS*DMODE_W-1:0] cfgDelMode,
  input  logic [NUM_PINS-1:0]         cfgLevel,
  input  logic [NUM_PINS-1:0]         cfgMask,
  input  logic [NUM_PINS-1:0]         cfgWrite,
  input  logic                        eoiValid,
  input  logic [VEC_W-1:0]            eoiVector,
  output logic                        msgValid,
  input  logic                        msgReady,
  input  logic                        msgHit,
  output logic [PIN_W-1:0]            msgPin,
  output logic [VEC_W-1:0]            msgVector,
  output logic [DEST_W-1:0]           msgDest,
  output logic [DMODE_W-1:0]          msgDelMode,
  output logic                        msgLevel
);
  ctlStrb_t            strb;
  logic [PIN_W-1:0]    selPin;
  logic [NUM_PINS-1:0] eligible;
  logic                stormReq;
  logic                slotValid;

  irq_pin_bank #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W),
    .DMODE_W(DMODE_W), .STORM_LIMIT(STORM_LIMIT), .PIN_W(PIN_W)
  ) i_bank (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel),
    .cfgVector(cfgVector), .cfgDest(cfgDest), .cfgDelMode(cfgDelMode),
    .cfgLevel(cfgLevel), .cfgMask(cfgMask), .cfgWrite(cfgWrite),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .msgReady(msgReady),
    .strb(strb), .selPin(selPin), .slotValid(slotValid),
    .eligible(eligible), .stormReq(stormReq),
    .msgPin(msgPin), .msgVector(msgVector), .msgDest(msgDest),
    .msgDelMode(msgDelMode), .msgLevel(msgLevel)
  );

  irq_deliver_ctl #(
    .NUM_PINS(NUM_PINS), .DELAY_CYCLES(DELAY_CYCLES), .PIN_W(PIN_W)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .stormReq(stormReq),
    .msgReady(msgReady), .msgHit(msgHit),
    .strb(strb), .selPin(selPin), .slotValid(slotValid)
  );

  assign msgValid = slotValid;
endmodule

// File: tb/test_irq_pin_dispatch.sv
module test_irq_pin_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int LIM = 4;
  localparam int DLY = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pinLevel = '0;
  logic [NP*8-1:0] cfgVector;
  logic [NP*8-1:0] cfgDest;
  logic [NP*3-1:0] cfgDelMode = '0;
  logic [NP-1:0] cfgLevel = 4'b0110;
  logic [NP-1:0] cfgMask = 4'b1100;
  logic [NP-1:0] cfgWrite = '0;
  logic eoiValid = 1'b0;
  logic [7:0] eoiVector = '0;
  logic msgValid, msgReady = 1'b0, msgHit = 1'b0, msgLevel;
  logic [1:0] msgPin;
  logic [7:0] msgVector, msgDest;
  logic [2:0] msgDelMode;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i < NP; i++) begin
      cfgVector[i*8 +: 8] = 8'h20 + 8'(i);
      cfgDest[i*8 +: 8]   = 8'h40 + 8'(i);
    end
  end

  irq_pin_dispatch #(.NUM_PINS(NP), .VEC_W(8), .DEST_W(8), .DMODE_W(3),
    .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY)) i_irq_pin_dispatch (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .cfgVector(cfgVector),
    .cfgDest(cfgDest), .cfgDelMode(cfgDelMode), .cfgLevel(cfgLevel),
    .cfgMask(cfgMask), .cfgWrite(cfgWrite), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .msgValid(msgValid), .msgReady(msgReady),
    .msgHit(msgHit), .msgPin(msgPin), .msgVector(msgVector),
    .msgDest(msgDest), .msgDelMode(msgDelMode), .msgLevel(msgLevel));

  task automatic expectMsg(input int pin, input logic hit, input int maxWait, input string tag);
    int waited = 0;
    while (!msgValid && waited < maxWait) begin
      @(negedge clk);
      waited++;
    end
    checks++;
    if (!msgValid) begin
      fails++;
      $display("FAIL %s: msgValid=0 expected message from pin %0d", tag, pin);
    end else begin
      if (msgPin != 2'(pin) || msgVector != 8'h20 + 8'(pin) || msgDest != 8'h40 + 8'(pin)) begin
        fails++;
        $display("FAIL %s: pin=%0d vec=%h dest=%h expected pin=%0d vec=%h dest=%h",
                 tag, msgPin, msgVector, msgDest, pin, 8'h20 + 8'(pin), 8'h40 + 8'(pin));
      end
      msgReady = 1'b1;
      msgHit = hit;
      @(negedge clk);
      msgReady = 1'b0;
      msgHit = 1'b0;
    end
  endtask

  task automatic expectNone(input int cycles, input string tag);
    bit seen = 0;
    int seenPin = 0;
    checks++;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (msgValid && !seen) begin
        seen = 1;
        seenPin = int'(msgPin);
      end
    end
    if (seen) begin
      fails++;
      $display("FAIL %s: message from pin %0d, expected no message", tag, seenPin);
    end
  endtask

  task automatic sendEoi(input logic [7:0] vec);
    @(negedge clk);
    eoiValid = 1'b1;
    eoiVector = vec;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  task automatic setPin(input int pin, input logic val);
    @(negedge clk);
    pinLevel[pin] = val;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checks++;
    if (msgValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: msgValid=%b during reset expected 0", msgValid);
    end
    rstN = 1'b1;
    expectNone(5, "R1");
  endtask

  task automatic testEdge();
    setPin(0, 1'b1);
    expectMsg(0, 1'b1, 20, "R2 edge rise");
    expectNone(10, "R2 held high coalesced");
    setPin(0, 1'b0);
  endtask

  task automatic testLevel();
    setPin(1, 1'b1);
    expectMsg(1, 1'b0, 20, "R5 level first");
    expectNone(8, "R5 no resend without event");
    setPin(1, 1'b0);
    setPin(1, 1'b1);
    expectMsg(1, 1'b1, 20, "R5 level after miss");
    setPin(1, 1'b0);
    setPin(1, 1'b1);
    expectNone(10, "R5 remote IRR blocks");
    sendEoi(8'h21);
    expectMsg(1, 1'b1, 20, "R6 EOI redelivers");
    sendEoi(8'h55);
    expectNone(10, "R6 unrelated vector");
    setPin(1, 1'b0);
    sendEoi(8'h21);
    expectNone(10, "R3 low pin not redelivered");
  endtask

  task automatic testMaskRewrite();
    setPin(2, 1'b1);
    expectNone(10, "R4 masked level silent");
    @(negedge clk);
    cfgMask[2] = 1'b0;
    cfgWrite[2] = 1'b1;
    @(negedge clk);
    cfgWrite[2] = 1'b0;
    expectMsg(2, 1'b0, 20, "R10 rewrite delivers recorded request");
    setPin(3, 1'b1);
    expectNone(10, "R4 masked edge silent");
  endtask

  task automatic testPriority();
    @(negedge clk);
    pinLevel[0] = 1'b1;
    pinLevel[1] = 1'b1;
    expectMsg(0, 1'b1, 20, "R11 lowest first");
    expectMsg(1, 1'b1, 20, "R11 second pin next");
  endtask

  task automatic testStorm();
    for (int k = 1; k < LIM; k++) begin
      sendEoi(8'h21);
      expectMsg(1, 1'b1, 20, "R7 redelivery under limit");
    end
    sendEoi(8'h21);
    expectNone(10, "R7 delivery postponed at limit");
    expectMsg(1, 1'b1, 60, "R7 delayed delivery pin1");
    expectMsg(2, 1'b1, 10, "R9 delayed delivery also pin2");
  endtask

  task automatic testCountReset();
    for (int k = 1; k < LIM; k++) begin
      sendEoi(8'h21);
      expectMsg(1, 1'b1, 20, "R8 build count");
    end
    setPin(1, 1'b0);
    sendEoi(8'h21);
    expectNone(5, "R8 idle EOI");
    setPin(1, 1'b1);
    expectMsg(1, 1'b1, 20, "R8 new rise");
    sendEoi(8'h21);
    expectMsg(1, 1'b1, 10, "R8 count restarted so immediate redelivery");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testEdge();
    testLevel();
    testMaskRewrite();
    testPriority();
    testStorm();
    testCountReset();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish();
  end
endmodule